// File: doc/BRIEF.md
# Cartridge Coprocessor Address Decoder

This block sits on a host bus that carries a 24-bit address, split into an 8-bit bank and a 16-bit offset. For each access it decides whether the address targets the coprocessor's data register, the coprocessor's status register, or neither. When it targets neither, the access falls through to the normal memory or unknown-I/O decoding elsewhere in the chip. The decoder also produces the read and write strobes that go to the coprocessor's port.

The decoder only responds once it has been enabled. Enabling comes from a cartridge-type code that is sampled from the cartridge header when a load strobe pulses. The bank window and the address bit that picks the register both depend on a memory-map mode input, which selects between the linear ("LoROM") and the high ("HiROM") layout.

The address decode itself is combinational. The only state in the block is the one-bit enable.

Top module: `cop_addr_dec`

## Requirements
- R1: After reset the enable is clear: `sel_data`, `sel_stat` and every strobe are low, and `fall_thru` is high for any address.
- R2: On a clock edge with `hdr_load` high, the enable takes the value (0x03 <= `hdr_type` <= 0x06). On an edge with `hdr_load` low, changes on `hdr_type` have no effect on the enable.
- R3: With `map_hi`=0, only banks 0x30 to 0x3F can hit. Any other bank gives `fall_thru`=1.
- R4: With `map_hi`=1, only banks 0x00 to 0x0F can hit. Any other bank gives `fall_thru`=1.
- R5: Offsets below 0x6000 never hit, in either mode.
- R6: With `map_hi`=1, bit 12 of (offset - 0x6000) selects the register:
  - offsets 0x6000 to 0x6FFF select data;
  - offsets 0x7000 to 0x7FFF select status;
  - offsets 0x8000 to 0xFFFF fall through.
- R7: With `map_hi`=0, bit 14 of (offset - 0x6000) selects the register:
  - offsets 0x6000 to 0x9FFF select data;
  - offsets 0xA000 to 0xDFFF select status;
  - offsets 0xE000 to 0xFFFF select data.
- R8: The strobes follow the selects:
  - `dr_rd` = `sel_data` & `rd`;
  - `dr_wr` = `sel_data` & `wr`;
  - `sr_rd` = `sel_stat` & `rd`.
- R9: A write that decodes to the status register raises only `sink_wr`. It produces no `dr_wr` and no `sr_rd`, so it has no effect on the coprocessor.
- R10: The selects follow the address and mode inputs in the same cycle, with no register in the path. A change of `map_hi` moves the window at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the enable register |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_load | input | 1 | Strobe that samples `hdr_type` into the enable |
| hdr_type | input | 8 | Cartridge-type code from the header |
| map_hi | input | 1 | Memory-map mode: 0 linear, 1 high |
| bank | input | 8 | Address bank |
| offset | input | 16 | Address offset within the bank |
| rd | input | 1 | Host read access |
| wr | input | 1 | Host write access |
| sel_data | output | 1 | Address decodes to the data register |
| sel_stat | output | 1 | Address decodes to the status register |
| fall_thru | output | 1 | Address is not claimed by the coprocessor |
| dr_rd | output | 1 | Read strobe to the data register |
| dr_wr | output | 1 | Write strobe to the data register |
| sr_rd | output | 1 | Read strobe to the status register |
| sink_wr | output | 1 | Status write sent to the unknown-I/O sink |

## Verification
The bench walks the edges of each window, to catch an off-by-one compare that would claim a neighbouring bank or the last offset below the window:
- banks 0x2F, 0x30, 0x3F, 0x40 and 0x00, 0x0F, 0x10;
- offsets 0x5FFF, 0x6000, 0x6FFF, 0x7000, 0x7FFF, 0x8000, 0x9FFF, 0xA000, 0xDFFF, 0xE000 and 0xFFFF.

In the linear layout, a decoder that used the wrong select bit would flag the top range 0xE000 to 0xFFFF as status instead of data. In the high layout, a wrong select bit would claim offsets from 0x8000 upward.

The header codes 0x02, 0x03, 0x06 and 0x07 are loaded, to catch a type-range compare that is too wide or too narrow. A type change without the load strobe must leave the window state as it was.

Status writes must reach only the sink. A design that passed them on as data writes would corrupt the coprocessor's input stream.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

   // Result of the register decode for one access
   typedef struct packed {
      logic hit;
      logic stat;
   } cdec_dec_t;

   // Selector codes for the bank-window compare variant
   typedef enum logic [0:0] {
      CMP_EXACT  = 1'b0,
      CMP_PREFIX = 1'b1
   } cdec_cmp_e;

endpackage

// File: rtl/cdec_hdr_en.sv
module cdec_hdr_en #(
   parameter int unsigned TYPE_W  = 8,
   parameter int unsigned TYPE_LO = 8'h03,
   parameter int unsigned TYPE_HI = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TYPE_W-1:0] type_code,
   output logic              en
);
   localparam logic [TYPE_W-1:0] LO_V = TYPE_W'(TYPE_LO);
   localparam logic [TYPE_W-1:0] HI_V = TYPE_W'(TYPE_HI);

   generate
      if (TYPE_LO > TYPE_HI) begin : g_bad_range
         $error("cdec_hdr_en: TYPE_LO above TYPE_HI");
      end
   endgenerate

   logic in_rng;
   assign in_rng = (type_code >= LO_V) && (type_code <= HI_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= 1'b0;
      else if (load)
         en <= in_rng;
   end

   // R2
   hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(en));
   // R2
   lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && type_code == LO_V) |=> en);
endmodule

// File: rtl/cdec_win.sv
module cdec_win
   import cdec_pkg::*;
#(
   parameter int unsigned            BANK_W      = 8,
   parameter int unsigned            SPAN_LOG2   = 4,
   parameter logic [BANK_W-1:0]      LO_BASE     = 8'h30,
   parameter logic [BANK_W-1:0]      HI_BASE     = 8'h00
) (
   input  logic [BANK_W-1:0] bank,
   input  logic              map_hi,
   output logic              bank_hit
);
   localparam cdec_cmp_e    CMP     = (SPAN_LOG2 == 0) ? CMP_EXACT : CMP_PREFIX;
   localparam logic [BANK_W-1:0] SPAN_MASK = BANK_W'((1 << SPAN_LOG2) - 1);

   generate
      if (SPAN_LOG2 >= BANK_W) begin : g_bad_span
         $error("cdec_win: window span covers every bank");
      end
      if (((LO_BASE & SPAN_MASK) != '0) || ((HI_BASE & SPAN_MASK) != '0)) begin : g_bad_base
         $error("cdec_win: window base not aligned to span");
      end
   endgenerate

   logic lo_hit, hi_hit;

   generate
      if (CMP == CMP_EXACT) begin : g_exact
         assign lo_hit = (bank == LO_BASE);
         assign hi_hit = (bank == HI_BASE);
      end else begin : g_prefix
         assign lo_hit = (bank[BANK_W-1:SPAN_LOG2] == LO_BASE[BANK_W-1:SPAN_LOG2]);
         assign hi_hit = (bank[BANK_W-1:SPAN_LOG2] == HI_BASE[BANK_W-1:SPAN_LOG2]);
      end
   endgenerate

   assign bank_hit = map_hi ? hi_hit : lo_hit;
endmodule

// File: rtl/cdec_regsel.sv
module cdec_regsel
   import cdec_pkg::*;
#(
   parameter int unsigned       OFS_W       = 16,
   parameter logic [OFS_W-1:0]  WIN_BASE    = 16'h6000,
   parameter int unsigned       HI_WIN_LOG2 = 13,
   parameter int unsigned       LO_SEL_BIT  = 14,
   parameter int unsigned       HI_SEL_BIT  = 12
) (
   input  logic [OFS_W-1:0] offset,
   input  logic             map_hi,
   output cdec_dec_t        dec
);
   generate
      if (HI_WIN_LOG2 >= OFS_W || HI_WIN_LOG2 == 0) begin : g_bad_win
         $error("cdec_regsel: high-mode window size out of range");
      end
      if (LO_SEL_BIT >= OFS_W || HI_SEL_BIT >= HI_WIN_LOG2) begin : g_bad_sel
         $error("cdec_regsel: select bit outside window");
      end
   endgenerate

   logic [OFS_W-1:0] rel;
   logic             above;
   logic             hi_in;

   assign rel = offset - WIN_BASE;

   generate
      if (WIN_BASE == '0) begin : g_no_floor
         assign above = 1'b1;
      end else begin : g_floor
         assign above = (offset >= WIN_BASE);
      end
   endgenerate

   assign hi_in = (rel[OFS_W-1:HI_WIN_LOG2] == '0);

   always_comb begin
      dec.hit  = above && (!map_hi || hi_in);
      dec.stat = map_hi ? rel[HI_SEL_BIT] : rel[LO_SEL_BIT];
   end
endmodule

// File: rtl/cop_addr_dec.sv
module cop_addr_dec
   import cdec_pkg::*;
#(
   parameter int unsigned BANK_W      = 8,
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned TYPE_W      = 8,
   parameter int unsigned TYPE_LO     = 8'h03,
   parameter int unsigned TYPE_HI     = 8'h06,
   parameter int unsigned SPAN_LOG2   = 4,
   parameter logic [BANK_W-1:0] LO_BASE  = 8'h30,
   parameter logic [BANK_W-1:0] HI_BASE  = 8'h00,
   parameter logic [OFS_W-1:0]  WIN_BASE = 16'h6000,
   parameter int unsigned HI_WIN_LOG2 = 13,
   parameter int unsigned LO_SEL_BIT  = 14,
   parameter int unsigned HI_SEL_BIT  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_load,
   input  logic [TYPE_W-1:0] hdr_type,
   input  logic              map_hi,
   input  logic [BANK_W-1:0] bank,
   input  logic [OFS_W-1:0]  offset,
   input  logic              rd,
   input  logic              wr,
   output logic              sel_data,
   output logic              sel_stat,
   output logic              fall_thru,
   output logic              dr_rd,
   output logic              dr_wr,
   output logic              sr_rd,
   output logic              sink_wr
);
   logic      en_q;
   logic      bank_hit;
   cdec_dec_t dec;
   logic      claim;

   cdec_hdr_en #(
      .TYPE_W (TYPE_W),
      .TYPE_LO(TYPE_LO),
      .TYPE_HI(TYPE_HI)
   ) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hdr_load),
      .type_code(hdr_type),
      .en       (en_q)
   );

   cdec_win #(
      .BANK_W   (BANK_W),
      .SPAN_LOG2(SPAN_LOG2),
      .LO_BASE  (LO_BASE),
      .HI_BASE  (HI_BASE)
   ) u_win (
      .bank    (bank),
      .map_hi  (map_hi),
      .bank_hit(bank_hit)
   );

   cdec_regsel #(
      .OFS_W      (OFS_W),
      .WIN_BASE   (WIN_BASE),
      .HI_WIN_LOG2(HI_WIN_LOG2),
      .LO_SEL_BIT (LO_SEL_BIT),
      .HI_SEL_BIT (HI_SEL_BIT)
   ) u_sel (
      .offset(offset),
      .map_hi(map_hi),
      .dec   (dec)
   );

   assign claim     = en_q && bank_hit && dec.hit;
   assign sel_data  = claim && !dec.stat;
   assign sel_stat  = claim &&  dec.stat;
   assign fall_thru = !claim;

   assign dr_rd   = sel_data && rd;
   assign dr_wr   = sel_data && wr;
   assign sr_rd   = sel_stat && rd;
   assign sink_wr = sel_stat && wr;

   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (fall_thru && !dr_rd && !dr_wr && !sr_rd && !sink_wr));
   // R5
   below_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (offset < WIN_BASE) |-> fall_thru);
   // R6
   hi_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map_hi && offset[OFS_W-1]) |-> fall_thru);
   // R9
   stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_stat && wr) |-> (sink_wr && !dr_wr && !sr_rd));
   // R8
   strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd && wr) |-> $onehot0({dr_rd, dr_wr, sr_rd, sink_wr}));
endmodule

// File: tb/sim_cop_addr_dec.sv
module sim_cop_addr_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_load = 1'b0;
   logic [7:0]  hdr_type = 8'h00;
   logic        map_hi = 1'b0;
   logic [7:0]  bank = 8'h00;
   logic [15:0] offset = 16'h0000;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic        sel_data, sel_stat, fall_thru, dr_rd, dr_wr, sr_rd, sink_wr;

   int checks = 0;
   int errors = 0;
   bit en_exp = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cop_addr_dec u0 (
      .clk(clk), .rst_n(rst_n), .hdr_load(hdr_load), .hdr_type(hdr_type),
      .map_hi(map_hi), .bank(bank), .offset(offset), .rd(rd), .wr(wr),
      .sel_data(sel_data), .sel_stat(sel_stat), .fall_thru(fall_thru),
      .dr_rd(dr_rd), .dr_wr(dr_wr), .sr_rd(sr_rd), .sink_wr(sink_wr)
   );

   // Expected {sel_data, sel_stat, fall_thru, dr_rd, dr_wr, sr_rd, sink_wr}
   function automatic logic [6:0] model(bit en, bit hi, logic [7:0] b,
                                        logic [15:0] o, bit r, bit w);
      bit hit = 1'b0;
      bit st  = 1'b0;
      if (en && o >= 16'h6000) begin
         if (!hi && b >= 8'h30 && b <= 8'h3F) begin
            hit = 1'b1;
            st  = (o >= 16'hA000 && o <= 16'hDFFF);
         end
         if (hi && b <= 8'h0F && o <= 16'h7FFF) begin
            hit = 1'b1;
            st  = (o >= 16'h7000);
         end
      end
      return {hit && !st, hit && st, !hit, hit && !st && r, hit && !st && w,
              hit && st && r, hit && st && w};
   endfunction

   task automatic probe(string req, bit hi, logic [7:0] b, logic [15:0] o,
                        bit r, bit w);
      logic [6:0] act, exp;
      @(negedge clk);
      map_hi = hi; bank = b; offset = o; rd = r; wr = w;
      #1;
      act = {sel_data, sel_stat, fall_thru, dr_rd, dr_wr, sr_rd, sink_wr};
      exp = model(en_exp, hi, b, o, r, w);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s hi=%0d bank=%h ofs=%h act=%b exp=%b",
                  req, hi, b, o, act, exp);
      end
   endtask

   task automatic load_hdr(logic [7:0] code);
      @(negedge clk);
      hdr_type = code; hdr_load = 1'b1;
      @(negedge clk);
      hdr_load = 1'b0;
      en_exp = (code >= 8'h03 && code <= 8'h06);
   endtask

   task automatic t_reset;
      probe("R1", 1'b0, 8'h30, 16'h6000, 1'b1, 1'b0);
      probe("R1", 1'b1, 8'h00, 16'h7000, 1'b0, 1'b1);
   endtask

   task automatic t_header;
      load_hdr(8'h02); probe("R2", 1'b0, 8'h30, 16'h6000, 1'b1, 1'b0);
      load_hdr(8'h03); probe("R2", 1'b0, 8'h30, 16'h6000, 1'b1, 1'b0);
      load_hdr(8'h07); probe("R2", 1'b0, 8'h30, 16'h6000, 1'b1, 1'b0);
      load_hdr(8'h06); probe("R2", 1'b0, 8'h30, 16'h6000, 1'b1, 1'b0);
      // type change without strobe: enable must stay set
      @(negedge clk); hdr_type = 8'hFF;
      @(negedge clk);
      probe("R2", 1'b0, 8'h35, 16'hA000, 1'b1, 1'b0);
   endtask

   task automatic t_banks;
      logic [7:0] lo_b [6] = '{8'h2F, 8'h30, 8'h37, 8'h3F, 8'h40, 8'h00};
      logic [7:0] hi_b [6] = '{8'h00, 8'h08, 8'h0F, 8'h10, 8'h30, 8'hFF};
      foreach (lo_b[i]) probe("R3", 1'b0, lo_b[i], 16'h8000, 1'b1, 1'b0);
      foreach (hi_b[i]) probe("R4", 1'b1, hi_b[i], 16'h6800, 1'b1, 1'b0);
   endtask

   task automatic t_low_ofs;
      probe("R5", 1'b0, 8'h30, 16'h5FFF, 1'b1, 1'b0);
      probe("R5", 1'b1, 8'h00, 16'h5FFF, 1'b1, 1'b0);
      probe("R5", 1'b0, 8'h3F, 16'h0000, 1'b0, 1'b1);
   endtask

   task automatic t_hi_sel;
      logic [15:0] o [6] = '{16'h6000, 16'h6FFF, 16'h7000, 16'h7FFF, 16'h8000, 16'hFFFF};
      foreach (o[i]) probe("R6", 1'b1, 8'h05, o[i], 1'b1, 1'b0);
   endtask

   task automatic t_lo_sel;
      logic [15:0] o [6] = '{16'h6000, 16'h9FFF, 16'hA000, 16'hDFFF, 16'hE000, 16'hFFFF};
      foreach (o[i]) probe("R7", 1'b0, 8'h3A, o[i], 1'b1, 1'b0);
   endtask

   task automatic t_strobes;
      probe("R8", 1'b0, 8'h30, 16'h6000, 1'b0, 1'b1);
      probe("R8", 1'b1, 8'h0F, 16'h7000, 1'b1, 1'b0);
      probe("R8", 1'b0, 8'h30, 16'h6000, 1'b0, 1'b0);
      probe("R9", 1'b0, 8'h3C, 16'hB000, 1'b0, 1'b1);
      probe("R9", 1'b1, 8'h01, 16'h7ABC, 1'b0, 1'b1);
   endtask

   task automatic t_mode;
      // same address, mode flipped: window moves without a clock
      probe("R10", 1'b0, 8'h02, 16'h6000, 1'b1, 1'b0);
      map_hi = 1'b1; #1;
      checks++;
      if ({sel_data, fall_thru} !== 2'b10) begin
         errors++;
         $display("FAIL R10 act=%b exp=10", {sel_data, fall_thru});
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_header();
      t_banks();
      t_low_ofs();
      t_hi_sel();
      t_lo_sel();
      t_strobes();
      t_mode();
      load_hdr(8'h00);
      probe("R2", 1'b1, 8'h00, 16'h6000, 1'b1, 1'b0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule